// File: doc/BRIEF.md
# Hardware Lock Queue Buffer

This block sits next to the shared-memory controller of a small multiprocessor and manages spin locks on behalf of the cores. A core sends an acquire request carrying its core number and a lock address; if nobody holds that lock the core is granted at once, otherwise the request is parked inside the block and the core simply waits for its grant instead of polling memory across the interconnect.

All pending requests of all locks live in one shared queue of `NCORES` slots, because each core can wait on at most one lock at a time. New requests join at the tail. When the holder of a lock releases it, an associative search over every slot finds the requests for the same address, and the oldest of them becomes the new holder and gets a grant pulse. A core thus pays a fixed number of transactions per acquisition however many others are contending. A release from a core that does not hold the lock is dropped and flagged.

Top module: `lock_queue_buffer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant_o` and `rel_err_o` are zero; reset empties the queue, so a lock held before reset is free after it.
- R2: An acquire for an address that no slot holds is granted: bit `acq_core_i` of `grant_o` is high in the cycle after the request, for exactly one cycle.
- R3: An acquire for an address that another core holds gives no grant and is queued as a waiter.
- R4: A release by the holder of an address passes the lock to a waiter of that same address, granting it in the cycle after the release; waiters and holders of other addresses are not affected.
- R5: Waiters of one address are granted in the order their acquires arrived, whatever the interleaving with other addresses.
- R6: A release whose core and address do not match a current holder raises `rel_err_o` for one cycle in the next cycle, gives no grant and leaves the queue unchanged.
- R7: A release by the holder when no waiter of that address exists frees the lock, so a later acquire of it is granted at once.
- R8: When an acquire and a release arrive in the same cycle, the release takes effect first: a waiter of the released address is served before the new request, and if there is none the new request finds the lock free.
- R9: The queue holds `NCORES` entries; all cores can be pending on a single address at once, and slots freed by releases are reused.
- R10: Locks at different addresses are granted and released independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_valid_i | input | 1 | One-cycle acquire request |
| acq_core_i | input | $clog2(NCORES) | Requesting core of the acquire |
| acq_addr_i | input | ADDR_W | Lock address of the acquire |
| rel_valid_i | input | 1 | One-cycle release request |
| rel_core_i | input | $clog2(NCORES) | Releasing core |
| rel_addr_i | input | ADDR_W | Lock address being released |
| grant_o | output | NCORES | Per-core grant pulse, registered |
| rel_err_o | output | 1 | Pulse for a release by a non-holder, registered |

## Verification
The main path is driven with a single uncontended lock, three cores queued on one address mixed with a second address, releases of the wrong address and by waiters, and acquires colliding with releases both with and without a waiter present. The uncontended case separates the free-lock path from queueing, the mixed-address run shows that the search picks by address and that age order survives removals from the middle of the queue, and the collisions show which of the two requests wins. A full queue on one address followed by a chain of releases shows every slot being reachable, and a reset taken while a lock is held shows that no stale ownership survives.

// File: rtl/lq_match.sv
module lq_match #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] key_i,
  input  logic [W-1:0]        probe_i,
  output logic [N-1:0]        hit_o
);
  // one comparator per slot: the associative search
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (key_i[g] == probe_i);
  end
endmodule

// File: rtl/lq_first.sv
module lq_first #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins: slot 0 is the oldest entry
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lock_queue_buffer.sv
module lock_queue_buffer #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              acq_valid_i,
  input  logic [$clog2(NCORES)-1:0]         acq_core_i,
  input  logic [ADDR_W-1:0]                 acq_addr_i,
  input  logic                              rel_valid_i,
  input  logic [$clog2(NCORES)-1:0]         rel_core_i,
  input  logic [ADDR_W-1:0]                 rel_addr_i,
  output logic [NCORES-1:0]                 grant_o,
  output logic                              rel_err_o
);
  localparam int CID_W = $clog2(NCORES);
  localparam int CNT_W = $clog2(NCORES + 1);

  // slot storage, kept in age order from slot 0
  logic [NCORES-1:0]             v_q, own_q;
  logic [NCORES-1:0][CID_W-1:0]  cid_q;
  logic [NCORES-1:0][ADDR_W-1:0] adr_q;
  logic [CNT_W-1:0]              cnt_q;

  // ---- release: find the holder slot ----
  logic [NCORES-1:0] rel_amatch, rel_cmatch, rel_hit;
  logic              rel_found;
  logic [CID_W-1:0]  rel_idx;

  lq_match #(.N(NCORES), .W(ADDR_W)) u_rel_addr (
    .valid_i(v_q), .key_i(adr_q), .probe_i(rel_addr_i), .hit_o(rel_amatch));
  lq_match #(.N(NCORES), .W(CID_W)) u_rel_core (
    .valid_i(v_q), .key_i(cid_q), .probe_i(rel_core_i), .hit_o(rel_cmatch));

  assign rel_hit = rel_amatch & rel_cmatch & own_q & {NCORES{rel_valid_i}};

  lq_first #(.N(NCORES), .IW(CID_W)) u_rel_pick (
    .req_i(rel_hit), .found_o(rel_found), .idx_o(rel_idx));

  // ---- close the gap left by the freed slot ----
  logic [NCORES-1:0]             v_sh, own_sh, v1, own1;
  logic [NCORES-1:0][CID_W-1:0]  cid_sh, cid1;
  logic [NCORES-1:0][ADDR_W-1:0] adr_sh, adr1;
  logic [CNT_W-1:0]              cnt1;

  assign v_sh   = {1'b0, v_q[NCORES-1:1]};
  assign own_sh = {1'b0, own_q[NCORES-1:1]};
  assign cid_sh = {{CID_W{1'b0}}, cid_q[NCORES-1:1]};
  assign adr_sh = {{ADDR_W{1'b0}}, adr_q[NCORES-1:1]};
  assign cnt1   = cnt_q - CNT_W'(rel_found);

  always_comb begin
    for (int i = 0; i < NCORES; i++) begin
      if (rel_found && i >= int'(rel_idx)) begin
        v1[i] = v_sh[i]; own1[i] = own_sh[i]; cid1[i] = cid_sh[i]; adr1[i] = adr_sh[i];
      end else begin
        v1[i] = v_q[i];  own1[i] = own_q[i];  cid1[i] = cid_q[i];  adr1[i] = adr_q[i];
      end
    end
  end

  // ---- hand over to the oldest waiter of the released address ----
  logic [NCORES-1:0] wait_amatch, wait_hit, busy_hit;
  logic              w_found;
  logic [CID_W-1:0]  w_idx;

  lq_match #(.N(NCORES), .W(ADDR_W)) u_wait_addr (
    .valid_i(v1 & ~own1), .key_i(adr1), .probe_i(rel_addr_i), .hit_o(wait_amatch));
  assign wait_hit = wait_amatch & {NCORES{rel_found}};

  lq_first #(.N(NCORES), .IW(CID_W)) u_wait_pick (
    .req_i(wait_hit), .found_o(w_found), .idx_o(w_idx));

  // ---- acquire: lock busy if any slot still names the address ----
  lq_match #(.N(NCORES), .W(ADDR_W)) u_busy (
    .valid_i(v1), .key_i(adr1), .probe_i(acq_addr_i), .hit_o(busy_hit));

  logic                          busy, acq_ok;
  logic [NCORES-1:0]             v_n, own_n, grant_n;
  logic [NCORES-1:0][CID_W-1:0]  cid_n;
  logic [NCORES-1:0][ADDR_W-1:0] adr_n;
  logic [CNT_W-1:0]              cnt_n;

  assign busy   = |busy_hit;
  assign acq_ok = acq_valid_i && (int'(cnt1) < NCORES);

  always_comb begin
    v_n = v1; own_n = own1; cid_n = cid1; adr_n = adr1;
    grant_n = '0;
    cnt_n = cnt1;
    if (w_found) begin
      own_n[w_idx] = 1'b1;
      grant_n[cid1[w_idx]] = 1'b1;
    end
    if (acq_ok) begin
      for (int i = 0; i < NCORES; i++) begin
        if (i == int'(cnt1)) begin
          v_n[i] = 1'b1; own_n[i] = !busy; cid_n[i] = acq_core_i; adr_n[i] = acq_addr_i;
        end
      end
      if (!busy) grant_n[acq_core_i] = 1'b1;
      cnt_n = cnt1 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0; own_q <= '0; cid_q <= '0; adr_q <= '0; cnt_q <= '0;
      grant_o <= '0; rel_err_o <= 1'b0;
    end else begin
      v_q <= v_n; own_q <= own_n; cid_q <= cid_n; adr_q <= adr_n; cnt_q <= cnt_n;
      grant_o   <= grant_n;
      rel_err_o <= rel_valid_i && !rel_found;
    end
  end

  // ---- assertions ----
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= NCORES);
  p_count_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(v_q) == int'(cnt_q));
  p_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
    rel_err_o |-> $past(rel_valid_i));

  for (genvar i = 0; i < NCORES - 1; i++) begin : g_prefix
    p_packed_r9: assert property (@(posedge clk) disable iff (rst)
      v_q[i+1] |-> v_q[i]);
  end

  for (genvar i = 0; i < NCORES; i++) begin : g_pair
    for (genvar j = i + 1; j < NCORES; j++) begin : g_j
      p_single_owner_r4: assert property (@(posedge clk) disable iff (rst)
        !(v_q[i] && v_q[j] && own_q[i] && own_q[j] && adr_q[i] == adr_q[j]));
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_gnt
    logic [NCORES-1:0] holds_c;
    for (genvar s = 0; s < NCORES; s++) begin : g_s
      assign holds_c[s] = v_q[s] && own_q[s] && (cid_q[s] == CID_W'(c));
    end
    p_grant_owner_r2: assert property (@(posedge clk) disable iff (rst)
      grant_o[c] |-> |holds_c);
  end
endmodule

// File: tb/tb_lock_queue_buffer.sv
`timescale 1ns/1ps
module tb_lock_queue_buffer;
  localparam int NC = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          acq_valid_i, rel_valid_i;
  logic [1:0]    acq_core_i, rel_core_i;
  logic [AW-1:0] acq_addr_i, rel_addr_i;
  logic [NC-1:0] grant_o;
  logic          rel_err_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  lock_queue_buffer #(.NCORES(NC), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .acq_valid_i(acq_valid_i), .acq_core_i(acq_core_i), .acq_addr_i(acq_addr_i),
    .rel_valid_i(rel_valid_i), .rel_core_i(rel_core_i), .rel_addr_i(rel_addr_i),
    .grant_o(grant_o), .rel_err_o(rel_err_o));

  typedef struct packed {
    logic          av;
    logic [1:0]    ac;
    logic [AW-1:0] aa;
    logic          rv;
    logic [1:0]    rc;
    logic [AW-1:0] ra;
    logic [NC-1:0] eg;
    logic          ee;
    logic [3:0]    req;
  } vec_t;

  localparam logic [AW-1:0] LA = 8'h10, LB = 8'h20, LC = 8'h30;
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1, 0, LA, 0, 0, 0,  4'b0001, 0, 2},  // R2 free lock
    '{1, 1, LA, 0, 0, 0,  4'b0000, 0, 3},  // R3 held -> queued
    '{1, 2, LB, 0, 0, 0,  4'b0100, 0, 10}, // R10 other address free
    '{1, 3, LA, 0, 0, 0,  4'b0000, 0, 3},  // R3 second waiter
    '{0, 0, 0,  1, 1, LA, 4'b0000, 1, 6},  // R6 waiter releases
    '{0, 0, 0,  1, 0, LB, 4'b0000, 1, 6},  // R6 wrong address
    '{0, 0, 0,  1, 0, LA, 4'b0010, 0, 4},  // R4 c1 takes A
    '{1, 0, LA, 1, 2, LB, 4'b0000, 0, 10}, // R10 B freed, c0 waits on A
    '{0, 0, 0,  1, 1, LA, 4'b1000, 0, 5},  // R5 c3 before c0
    '{1, 2, LA, 1, 3, LA, 4'b0001, 0, 8},  // R8 waiter c0 beats new c2
    '{1, 1, LB, 0, 0, 0,  4'b0010, 0, 7},  // R7 B was freed
    '{0, 0, 0,  1, 0, LA, 4'b0100, 0, 5},  // R5 c2 next
    '{1, 3, LA, 1, 2, LA, 4'b1000, 0, 8},  // R8 no waiter: new acquire wins
    '{0, 0, 0,  1, 1, LB, 4'b0000, 0, 7},  // R7 B freed
    '{0, 0, 0,  1, 3, LA, 4'b0000, 0, 7},  // R7 A freed
    '{0, 0, 0,  0, 0, 0,  4'b0000, 0, 6},  // R6 idle, err pulse gone
    '{1, 0, LC, 0, 0, 0,  4'b0001, 0, 9},  // R9 fill all slots on C
    '{1, 1, LC, 0, 0, 0,  4'b0000, 0, 9},
    '{1, 2, LC, 0, 0, 0,  4'b0000, 0, 9},
    '{1, 3, LC, 0, 0, 0,  4'b0000, 0, 9},
    '{0, 0, 0,  1, 0, LC, 4'b0010, 0, 9},  // R9 chain of releases
    '{0, 0, 0,  1, 1, LC, 4'b0100, 0, 9},
    '{0, 0, 0,  1, 2, LC, 4'b1000, 0, 9},
    '{1, 1, LC, 1, 3, LC, 4'b0010, 0, 9}   // R9 slot reused after drain
  };

  task automatic drive(input logic av, input logic [1:0] ac, input logic [AW-1:0] aa,
                       input logic rv, input logic [1:0] rc, input logic [AW-1:0] ra);
    acq_valid_i = av; acq_core_i = ac; acq_addr_i = aa;
    rel_valid_i = rv; rel_core_i = rc; rel_addr_i = ra;
  endtask

  task automatic check(input string tag, input logic [NC-1:0] eg, input logic ee);
    checks++;
    if (grant_o !== eg || rel_err_o !== ee) begin
      errors++;
      $display("FAIL %s: grant=%b err=%b expected grant=%b err=%b", tag, grant_o, rel_err_o, eg, ee);
    end
  endtask

  // one request cycle: drive at negedge, sample mid-high after the edge
  task automatic cyc(input string tag, input logic av, input logic [1:0] ac, input logic [AW-1:0] aa,
                     input logic rv, input logic [1:0] rc, input logic [AW-1:0] ra,
                     input logic [NC-1:0] eg, input logic ee);
    @(negedge clk);
    drive(av, ac, aa, rv, rc, ra);
    @(posedge clk);
    #5;
    check(tag, eg, ee);
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #5;
    check("R1 in reset", '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #5;
    check("R1 after reset", '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cyc($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].av, VEC[i].ac, VEC[i].aa,
          VEC[i].rv, VEC[i].rc, VEC[i].ra, VEC[i].eg, VEC[i].ee);
    end
    // drain c1 on C
    cyc("R7 drain", 0, 0, 0, 1, 1, LC, 4'b0000, 1'b0);

    // R6: bad release leaves queue intact (holder and waiter order kept)
    cyc("R2 hold", 1, 2, LB, 0, 0, 0, 4'b0100, 1'b0);
    cyc("R3 wait", 1, 0, LB, 0, 0, 0, 4'b0000, 1'b0);
    cyc("R6 non-holder", 0, 0, 0, 1, 3, LB, 4'b0000, 1'b1);
    cyc("R6 queue kept", 0, 0, 0, 1, 2, LB, 4'b0001, 1'b0);

    // R1: reset while a lock is held and another core waits
    cyc("R3 wait again", 1, 1, LB, 0, 0, 0, 4'b0000, 1'b0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    #5;
    check("R1 reset mid-use", '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    cyc("R1 lock free after reset", 1, 1, LB, 0, 0, 0, 4'b0010, 1'b0);
    cyc("R1 old holder gone", 0, 0, 0, 1, 0, LB, 4'b0000, 1'b1);
    cyc("R7 release", 0, 0, 0, 1, 1, LB, 4'b0000, 1'b0);
    cyc("R2 pulse one cycle", 0, 0, 0, 0, 0, 0, 4'b0000, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule